// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the serial side of a byte-wide memory with 64K locations. A bus master reaches it over a two-wire link made of a clock line and a data line. The block runs on a fast system clock. It oversamples both lines through a two-flop synchronizer and finds the bus conditions and bit edges in the sampled values. It pulls the data line low through an output-enable pin and never drives it high. On its memory side it has a plain single-cycle write strobe and read strobe. Read data must be valid in the cycle after the read strobe.

A transfer starts with a select byte. The byte carries a fixed family code, the three strapped pin bits and a direction bit. For a write, the master sends the high and low bytes of a 16-bit pointer and then any number of data bytes. For a random read, the master sends the pointer and then a repeated START with a read select. Read streams go on for as long as the master acknowledges each byte.

Top module: `twi_mem_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sda_oe`, `mem_we` and `mem_re` are low.
- R2: A select byte sent most significant bit first, made of 4'b1010, then `pin_sel[2]`, `pin_sel[1]`, `pin_sel[0]`, then the direction bit (1 = read), is acknowledged: SDA is low during the ninth SCL high phase.
- R3: If the three strap bits in the select byte differ from `pin_sel`, that byte and every later byte up to the next START get no acknowledge, and no memory strobe is issued.
- R4: A select byte whose upper nibble is not 4'b1010 is not acknowledged.
- R5: In a write, the first byte after the select loads the pointer's high half and the second loads its low half. Each later byte produces exactly one single-cycle `mem_we` with `mem_addr` equal to the pointer. Every received byte is acknowledged.
- R6: A read select makes the block send the byte at the current pointer, most significant bit first. A repeated START after the two pointer bytes starts the read at that pointer. A read select with no pointer bytes continues from the pointer left by the previous access. `mem_re` lasts one cycle and `mem_addr` holds afterwards.
- R7: After every memory access the pointer steps by one, and it wraps from 16'hFFFF to 16'h0000. This holds for writes and for reads.
- R8: A master acknowledge (SDA low in the ninth clock after a sent byte) fetches the next byte. A not-acknowledge ends the read: no further `mem_re`, and SDA stays released.
- R9: Bytes clocked after a STOP without a new START are ignored: no acknowledge and no memory write.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| pin_sel | input | 3 | Strapped device address bits |
| mem_addr | output | ADDR_W | Memory address for the current strobe |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_re | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |

## Verification
Two things can happen together in the same SCL low phase. The block releases its acknowledge on the data line, and the master raises that line to set up a repeated START. If the release comes late or the START detector misreads the edge, the pointer gets lost or a false STOP is seen. The bench provokes this with a repeated START right after the low pointer byte's acknowledge, in both the plain and the wrapped random read. It judges the result by the first byte that comes back against its own memory model, and by a watch on every clock that `sda_oe` never moves while SCL is high.

// File: rtl/twi_mem_target.sv
module twi_mem_target #(
  parameter int ADDR_W = 16,
  parameter logic [3:0] FAMILY = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        pin_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_RD0, S_RD1, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_SEL, P_HI, P_LO, P_DAT} ph_t;

  st_t st;
  ph_t ph;
  logic [2:0] scl_sh, sda_sh;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic [ADDR_W-1:0] ptr;
  logic rw, more;

  wire scl_r = scl_sh[1];
  wire scl_d = scl_sh[2];
  wire sda_r = sda_sh[1];
  wire sda_d = sda_sh[2];
  wire scl_rise = scl_r & ~scl_d;
  wire scl_fall = ~scl_r & scl_d;
  wire start = scl_r & scl_d & sda_d & ~sda_r;
  wire stop = scl_r & scl_d & ~sda_d & sda_r;
  wire sel_hit = (sh[7:4] == FAMILY) && (sh[3:1] == pin_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_SEL;
      sh <= '0;
      cnt <= '0;
      ptr <= '0;
      rw <= 1'b0;
      more <= 1'b0;
      sda_oe <= 1'b0;
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      if (start) begin
        st <= S_RX;
        ph <= P_SEL;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh <= {sh[6:0], sda_r};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (ph)
                P_SEL: begin
                  if (sel_hit) begin
                    rw <= sh[0];
                    sda_oe <= 1'b1;
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                P_HI, P_LO: begin
                  ptr <= {ptr[ADDR_W-9:0], sh};
                  sda_oe <= 1'b1;
                  st <= S_ACK;
                end
                default: begin
                  mem_we <= 1'b1;
                  mem_addr <= ptr;
                  mem_wdata <= sh;
                  ptr <= ptr + 1'b1;
                  sda_oe <= 1'b1;
                  st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt <= '0;
              if (ph == P_SEL && rw) begin
                mem_re <= 1'b1;
                mem_addr <= ptr;
                ptr <= ptr + 1'b1;
                st <= S_RD0;
              end else begin
                st <= S_RX;
                ph <= (ph == P_SEL) ? P_HI : (ph == P_HI) ? P_LO : P_DAT;
              end
            end
          end
          S_RD0: st <= S_RD1;
          S_RD1: begin
            sh <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
            cnt <= '0;
            st <= S_TX;
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st <= S_MACK;
              end else begin
                sda_oe <= ~sh[6];
                sh <= {sh[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              more <= ~sda_r;
            end else if (scl_fall) begin
              if (more) begin
                mem_re <= 1'b1;
                mem_addr <= ptr;
                ptr <= ptr + 1'b1;
                st <= S_RD0;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_we, mem_re})); // R5
  AST_WE_ONE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R5
  AST_RE_ONE: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re); // R6
  AST_RE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> $stable(mem_addr)); // R6
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sda_oe) |-> !scl_i); // R10

endmodule

bind twi_mem_target twi_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_twi_mem_target.sv
module sim_twi_mem_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  int n_we = 0;
  int n_re = 0;
  logic [7:0] bmem [int];

  always #10 clk = ~clk;

  twi_mem_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_sel(pins), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] fill(input int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd(input int a);
    return bmem.exists(a) ? bmem[a] : fill(a);
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[int'(mem_addr)] = mem_wdata;
      n_we++;
    end
    if (mem_re) begin
      mem_rdata <= rd(int'(mem_addr));
      n_re++;
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) begin
      n_bad++;
      $display("FAIL R10: sda_oe moved to %0b while SCL high (expected no change)", sda_oe);
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; w(5);
    scl_m = 1'b1; w(5);
    r = sda_line; w(5);
    scl_m = 1'b0; w(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(5);
    scl_m = 1'b1; w(5);
    sda_m = 1'b0; w(5);
    scl_m = 1'b0; w(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(5);
    scl_m = 1'b1; w(5);
    sda_m = 1'b1; w(10);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~mack, r);
  endtask

  logic [7:0] sel_w, sel_r;

  initial begin
    logic a;
    logic [7:0] d;
    int we0, re0;
    sel_w = {4'b1010, pins, 1'b0};
    sel_r = {4'b1010, pins, 1'b1};
    w(5);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 in reset", {sda_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1 after reset", {sda_oe, mem_we, mem_re}, 0);

    bus_start();
    send_byte(sel_w, a); chk(a, "R2 write select ack", a, 1);
    send_byte(8'h12, a); chk(a, "R5 high pointer ack", a, 1);
    send_byte(8'h34, a); chk(a, "R5 low pointer ack", a, 1);
    send_byte(8'hC1, a); chk(a, "R5 data ack", a, 1);
    send_byte(8'hC2, a);
    send_byte(8'hC3, a);
    bus_stop();
    chk(rd(32'h1234) == 8'hC1, "R5 byte at 1234", rd(32'h1234), 8'hC1);
    chk(rd(32'h1235) == 8'hC2, "R7 write step 1235", rd(32'h1235), 8'hC2);
    chk(rd(32'h1236) == 8'hC3, "R7 write step 1236", rd(32'h1236), 8'hC3);
    chk(n_we == 3, "R5 write strobe count", n_we, 3);

    we0 = n_we; re0 = n_re;
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, a); chk(!a, "R3 strap mismatch no ack", a, 0);
    send_byte(8'h12, a); chk(!a, "R3 silent after mismatch", a, 0);
    send_byte(8'h55, a);
    bus_stop();
    chk(n_we == we0 && n_re == re0, "R3 no memory strobe", n_we + n_re, we0 + re0);

    bus_start();
    send_byte({4'b1011, pins, 1'b0}, a); chk(!a, "R4 family mismatch no ack", a, 0);
    bus_stop();

    scl_m = 1'b0; w(5);
    send_byte(sel_w, a); chk(!a, "R9 no START no ack", a, 0);
    send_byte(8'h00, a);
    bus_stop();
    chk(n_we == we0, "R9 no write without START", n_we, we0);

    re0 = n_re;
    bus_start();
    send_byte(sel_w, a);
    send_byte(8'h12, a);
    send_byte(8'h35, a);
    bus_start();
    send_byte(sel_r, a); chk(a, "R2 read select ack", a, 1);
    recv_byte(d, 1'b1); chk(d == 8'hC2, "R6 random read", d, 8'hC2);
    recv_byte(d, 1'b0); chk(d == 8'hC3, "R7 sequential read", d, 8'hC3);
    bus_stop();
    w(60);
    chk(n_re == re0 + 2, "R8 NACK ends fetches", n_re - re0, 2);
    chk(sda_oe == 1'b0, "R8 SDA released", sda_oe, 0);

    bus_start();
    send_byte(sel_w, a);
    send_byte(8'hFF, a);
    send_byte(8'hFF, a);
    send_byte(8'h77, a);
    send_byte(8'h88, a);
    bus_stop();
    chk(rd(32'hFFFF) == 8'h77, "R5 byte at FFFF", rd(32'hFFFF), 8'h77);
    chk(rd(0) == 8'h88, "R7 write wrap to 0000", rd(0), 8'h88);

    bus_start();
    send_byte(sel_w, a);
    send_byte(8'hFF, a);
    send_byte(8'hFF, a);
    bus_start();
    send_byte(sel_r, a);
    recv_byte(d, 1'b1); chk(d == 8'h77, "R6 read at FFFF", d, 8'h77);
    recv_byte(d, 1'b0); chk(d == 8'h88, "R7 read wrap to 0000", d, 8'h88);
    bus_stop();

    bus_start();
    send_byte(sel_r, a); chk(a, "R6 current address select ack", a, 1);
    recv_byte(d, 1'b0); chk(d == fill(1), "R6 current address read", d, fill(1));
    bus_stop();
    w(20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end (expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule